// File: doc/BRIEF.md
# Four-Port Interleaved Banked Scratchpad

This block is an on-chip scratchpad that can accept up to four independent word accesses in a single clock cycle. Storage is split into four single-port banks. The two lowest address bits choose a bank, so consecutive words fall in consecutive banks. A request crossbar steers each port's access to the bank it addresses. A response crossbar returns read data one cycle later to the port that issued the read.

Each port has a valid/ready request channel that carries an address, a write enable and write data. Each port also has a read-data valid output. When several ports address the same bank in one cycle, only the lowest-numbered of them is granted. The others see ready low and must hold their request until they are granted. A write and a read aimed at the same bank therefore never share a cycle, and a read always returns a whole word.

Top module: `quad_bank_spm`

## Requirements
- R1: A request address is split as {row, bank}. Bits [1:0] select bank 0 to 3 by their binary value. The upper bits, [ADDR_W-1:2], select the row inside that bank. With the defaults ADDR_W is 10, so address 1023 is row 255 of bank 3 and address 1020 is row 255 of bank 0.
- R2: When all four ports present valid requests to four different banks, all four ready outputs are high in that cycle and all four accesses complete.
- R3: When two or more valid requests address the same bank, ready is high only for the lowest-numbered of those ports. The other ports see ready low.
- R4: A port that holds a stalled request unchanged is granted once no lower-numbered port addresses its bank, and its access then takes effect exactly as if it had not been stalled.
- R5: A read accepted on port p (valid, ready and write enable low at a rising edge) raises rsp_valid[p] for exactly the following cycle. In that cycle rsp_rdata for port p holds the word stored at the address read. In every other case rsp_valid[p] is low.
- R6: A write accepted at a rising edge stores its data at that edge and produces no read response. A read of that address accepted on any later cycle returns the new word.
- R7: A write and a read to the same bank in the same cycle are ordered by port priority. If the write port is lower-numbered, a later read returns the new word. If the read port is lower-numbered, it returns the previous word.
- R8: A port whose valid is low never sees ready high, and its write enable, address and data have no effect on memory contents.
- R9: While reset is low at a rising edge, no response is produced: rsp_valid is all zero in the following cycle, even if a read was presented. Memory contents are not cleared.
- R10: Words in the same row of different banks are independent: writing row r of one bank leaves row r of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 4 | Per-port request valid, bit p for port p |
| req_we | input | 4 | Per-port write enable, 1 for write, 0 for read |
| req_addr | input | 4*ADDR_W | Per-port word address, port p at [p*ADDR_W +: ADDR_W] |
| req_wdata | input | 4*DATA_W | Per-port write data, port p at [p*DATA_W +: DATA_W] |
| req_ready | output | 4 | Per-port grant; the request is taken at the edge where valid and ready are both high |
| rsp_valid | output | 4 | Per-port read response valid, one cycle after the read is accepted |
| rsp_rdata | output | 4*DATA_W | Per-port read data, port p at [p*DATA_W +: DATA_W] |

## Verification
A fault in the per-bank grant shows up at once, in the same cycle, as a wrong ready pattern. Two ready bits may rise for one bank, or the wrong port may win. A corrupted return tag is seen one cycle later: the response lands on the wrong port, or rsp_valid rises with no read behind it. A bank that decodes the row or bank bits wrongly stays hidden until a later read of that word. The stimulus therefore writes to distinct rows and banks, including the highest address, and reads every one of those words back with the ports permuted.

// File: rtl/spm_pkg.sv
package spm_pkg;
    // Structural constants shared by the scratchpad modules.
    localparam int unsigned SPM_PORTS  = 4;
    localparam int unsigned SPM_BANKS  = 4;
    localparam int unsigned SPM_BSEL_W = $clog2(SPM_BANKS);
    localparam int unsigned SPM_PIDX_W = $clog2(SPM_PORTS);
endpackage

// File: rtl/spm_xbar_arb.sv
// Per-bank fixed-priority arbiter: the lowest-numbered requesting port wins.
module spm_xbar_arb
    import spm_pkg::*;
#(
    parameter int unsigned NPORT  = SPM_PORTS,
    parameter int unsigned NBANK  = SPM_BANKS,
    localparam int unsigned BSEL_W = $clog2(NBANK),
    localparam int unsigned PIDX_W = $clog2(NPORT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              valid,
    input  logic [NPORT-1:0][BSEL_W-1:0]  bank_sel,
    output logic [NPORT-1:0]              ready,
    output logic [NBANK-1:0]              bank_en,
    output logic [NBANK-1:0][PIDX_W-1:0]  bank_port
);
    logic [NBANK-1:0][NPORT-1:0] gnt;

    always_comb begin
        gnt       = '0;
        bank_en   = '0;
        bank_port = '0;
        for (int b = 0; b < NBANK; b++) begin
            // descending scan so the lowest-numbered port is written last
            for (int p = NPORT - 1; p >= 0; p--) begin
                if (valid[p] && (bank_sel[p] == BSEL_W'(b))) begin
                    gnt[b]       = '0;
                    gnt[b][p]    = 1'b1;
                    bank_en[b]   = 1'b1;
                    bank_port[b] = PIDX_W'(p);
                end
            end
        end
    end

    always_comb begin
        ready = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int b = 0; b < NBANK; b++) begin
                ready[p] = ready[p] | gnt[b][p];
            end
        end
    end

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_rdy_chk
        assert_idle_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !valid[gp] |-> !ready[gp]);
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_gnt_chk
        assert_one_winner_per_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[gb]));
    end
endmodule

// File: rtl/spm_bank.sv
// Single-port bank with a registered read port (one cycle of read latency).
module spm_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ROWS   = 256,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bank_st_t;

    logic [DATA_W-1:0] mem [ROWS];
    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en && !we) begin
            st_d.rdata = mem[row];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[row] <= wdata;
        end
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/spm_rsp_route.sv
// Registers the winning port of every bank read and steers bank data back to it.
module spm_rsp_route
    import spm_pkg::*;
#(
    parameter int unsigned NPORT  = SPM_PORTS,
    parameter int unsigned NBANK  = SPM_BANKS,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned PIDX_W = $clog2(NPORT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NBANK-1:0]              bank_en,
    input  logic [NBANK-1:0]              bank_we,
    input  logic [NBANK-1:0][PIDX_W-1:0]  bank_port,
    input  logic [NBANK-1:0][DATA_W-1:0]  bank_rdata,
    output logic [NPORT-1:0]              rsp_valid,
    output logic [NPORT-1:0][DATA_W-1:0]  rsp_rdata
);
    typedef struct packed {
        logic [NBANK-1:0]             vld;
        logic [NBANK-1:0][PIDX_W-1:0] port;
    } tag_st_t;

    tag_st_t st_d, st_q;
    logic [NPORT-1:0][NBANK-1:0] hit;

    always_comb begin
        st_d.vld  = bank_en & ~bank_we;
        st_d.port = bank_port;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        hit       = '0;
        rsp_valid = '0;
        rsp_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int b = 0; b < NBANK; b++) begin
                if (st_q.vld[b] && (st_q.port[b] == PIDX_W'(p))) begin
                    hit[p][b]    = 1'b1;
                    rsp_valid[p] = 1'b1;
                    rsp_rdata[p] = bank_rdata[b];
                end
            end
        end
    end

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_hit_chk
        assert_single_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit[gp]) <= 1);
    end
endmodule

// File: rtl/quad_bank_spm.sv
// Four-port scratchpad over four word-interleaved banks.
module quad_bank_spm
    import spm_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ROWS   = 256,
    localparam int unsigned NPORT  = SPM_PORTS,
    localparam int unsigned NBANK  = SPM_BANKS,
    localparam int unsigned BSEL_W = SPM_BSEL_W,
    localparam int unsigned PIDX_W = SPM_PIDX_W,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned ADDR_W = ROW_W + BSEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_valid,
    input  logic [NPORT-1:0]          req_we,
    input  logic [NPORT*ADDR_W-1:0]   req_addr,
    input  logic [NPORT*DATA_W-1:0]   req_wdata,
    output logic [NPORT-1:0]          req_ready,
    output logic [NPORT-1:0]          rsp_valid,
    output logic [NPORT*DATA_W-1:0]   rsp_rdata
);
    logic [NPORT-1:0][BSEL_W-1:0] bank_sel;
    logic [NPORT-1:0][ROW_W-1:0]  port_row;
    logic [NPORT-1:0][DATA_W-1:0] port_wdata;
    logic [NBANK-1:0]             bank_en;
    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0][PIDX_W-1:0] bank_port;
    logic [NBANK-1:0][ROW_W-1:0]  bank_row;
    logic [NBANK-1:0][DATA_W-1:0] bank_wdata;
    logic [NBANK-1:0][DATA_W-1:0] bank_rdata;
    logic [NPORT-1:0][DATA_W-1:0] rsp_rdata_a;

    // address split: low bits pick the bank, the rest pick the row
    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        assign bank_sel[gp]   = req_addr[gp*ADDR_W +: BSEL_W];
        assign port_row[gp]   = req_addr[gp*ADDR_W + BSEL_W +: ROW_W];
        assign port_wdata[gp] = req_wdata[gp*DATA_W +: DATA_W];
        assign rsp_rdata[gp*DATA_W +: DATA_W] = rsp_rdata_a[gp];
    end

    spm_xbar_arb #(
        .NPORT (NPORT),
        .NBANK (NBANK)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .bank_sel  (bank_sel),
        .ready     (req_ready),
        .bank_en   (bank_en),
        .bank_port (bank_port)
    );

    // request crossbar: each bank takes the fields of its granted port
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            bank_we[b]    = bank_en[b] & req_we[bank_port[b]];
            bank_row[b]   = port_row[bank_port[b]];
            bank_wdata[b] = port_wdata[bank_port[b]];
        end
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        spm_bank #(
            .DATA_W (DATA_W),
            .ROWS   (ROWS)
        ) u_bank (
            .clk   (clk),
            .en    (bank_en[gb]),
            .we    (bank_we[gb]),
            .row   (bank_row[gb]),
            .wdata (bank_wdata[gb]),
            .rdata (bank_rdata[gb])
        );
    end

    spm_rsp_route #(
        .NPORT  (NPORT),
        .NBANK  (NBANK),
        .DATA_W (DATA_W)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_en    (bank_en),
        .bank_we    (bank_we),
        .bank_port  (bank_port),
        .bank_rdata (bank_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata_a)
    );

    // ---------------- port-level properties ----------------
    logic [NBANK-1:0] banks_used;
    always_comb begin
        banks_used = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (req_valid[p]) banks_used[bank_sel[p]] = 1'b1;
        end
    end

    assert_full_parallel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&req_valid && ($countones(banks_used) == NPORT)) |-> &req_ready);

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port_chk
        assert_read_resp_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[gp] && req_ready[gp] && !req_we[gp]) |=> rsp_valid[gp]);
        assert_resp_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[gp] |-> $past(req_valid[gp] && req_ready[gp] && !req_we[gp]));
        assert_write_no_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[gp] && req_ready[gp] && req_we[gp]) |=> !rsp_valid[gp]);
        for (genvar gq = 0; gq < gp; gq++) begin : g_prio
            assert_lower_port_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
                req_ready[gp] |-> !(req_valid[gq] && (bank_sel[gq] == bank_sel[gp])));
        end
    end
endmodule

// File: tb/quad_bank_spm_tb.sv
`timescale 1ns/1ps
module quad_bank_spm_tb;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    req_valid = '0;
    logic [3:0]    req_we = '0;
    logic [4*AW-1:0] req_addr = '0;
    logic [4*DW-1:0] req_wdata = '0;
    logic [3:0]    req_ready;
    logic [3:0]    rsp_valid;
    logic [4*DW-1:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] model   [1024];
    bit            written [1024];
    bit            pend_v  [4];
    bit            pend_k  [4];
    logic [DW-1:0] pend_d  [4];

    always #4 clk = ~clk;

    quad_bank_spm u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // {valid, we, addr3..addr0, data3..data0, expected ready}
    localparam logic [115:0] VEC [NV] = '{
        {4'hF, 4'hF, 10'd23, 10'd22, 10'd21, 10'd20, 16'hA003, 16'hA002, 16'hA001, 16'hA000, 4'hF},
        {4'hF, 4'h0, 10'd20, 10'd21, 10'd22, 10'd23, 16'h0, 16'h0, 16'h0, 16'h0, 4'hF},
        {4'hF, 4'hF, 10'd53, 10'd49, 10'd45, 10'd41, 16'hB003, 16'hB002, 16'hB001, 16'hB000, 4'h1},
        {4'hE, 4'hE, 10'd53, 10'd49, 10'd45, 10'd41, 16'hB003, 16'hB002, 16'hB001, 16'hB000, 4'h2},
        {4'hC, 4'hC, 10'd53, 10'd49, 10'd45, 10'd41, 16'hB003, 16'hB002, 16'hB001, 16'hB000, 4'h4},
        {4'h8, 4'h8, 10'd53, 10'd49, 10'd45, 10'd41, 16'hB003, 16'hB002, 16'hB001, 16'hB000, 4'h8},
        {4'hF, 4'h0, 10'd23, 10'd22, 10'd20, 10'd41, 16'h0, 16'h0, 16'h0, 16'h0, 4'hF},
        {4'h1, 4'h0, 10'd0, 10'd0, 10'd0, 10'd53, 16'h0, 16'h0, 16'h0, 16'h0, 4'h1},
        {4'h3, 4'h1, 10'd0, 10'd0, 10'd20, 10'd20, 16'h0, 16'h0, 16'h0, 16'hC000, 4'h1},
        {4'h2, 4'h0, 10'd0, 10'd0, 10'd20, 10'd0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h2},
        {4'h5, 4'h4, 10'd0, 10'd21, 10'd0, 10'd21, 16'h0, 16'hD000, 16'h0, 16'h0, 4'h1},
        {4'h4, 4'h4, 10'd0, 10'd21, 10'd0, 10'd0, 16'h0, 16'hD000, 16'h0, 16'h0, 4'h4},
        {4'h9, 4'h0, 10'd21, 10'd0, 10'd0, 10'd22, 16'h0, 16'h0, 16'h0, 16'h0, 4'h9},
        {4'h0, 4'hF, 10'd21, 10'd21, 10'd21, 10'd21, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'h0},
        {4'h1, 4'h0, 10'd0, 10'd0, 10'd0, 10'd21, 16'h0, 16'h0, 16'h0, 16'h0, 4'h1},
        {4'h3, 4'h3, 10'd0, 10'd0, 10'd1020, 10'd1023, 16'h0, 16'h0, 16'h1234, 16'hFFFF, 4'h3},
        {4'h3, 4'h0, 10'd0, 10'd0, 10'd1023, 10'd1020, 16'h0, 16'h0, 16'h0, 16'h0, 4'h3},
        {4'hC, 4'hC, 10'd29, 10'd28, 10'd0, 10'd0, 16'h2222, 16'h1111, 16'h0, 16'h0, 4'hC},
        {4'h3, 4'h0, 10'd0, 10'd0, 10'd28, 10'd29, 16'h0, 16'h0, 16'h0, 16'h0, 4'h3},
        {4'h0, 4'h0, 10'd0, 10'd0, 10'd0, 10'd0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0}
    };

    function automatic string tag_of(int i);
        case (i)
            0:       return "R1/R2";
            1:       return "R1/R2/R5";
            2:       return "R3";
            3, 4, 5: return "R3/R4";
            6, 7:    return "R4/R6";
            8, 9:    return "R7";
            10, 11:  return "R7";
            12:      return "R7/R5";
            13, 14:  return "R8";
            15, 16:  return "R1";
            default: return "R10";
        endcase
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare outputs caused by the previous edge against the bench model
    task automatic check_rsp(input string req);
        for (int p = 0; p < 4; p++) begin
            check(rsp_valid[p] === pend_v[p], req, $sformatf("rsp_valid port %0d", p),
                  DW'(rsp_valid[p]), DW'(pend_v[p]));
            if (pend_v[p] && pend_k[p])
                check(rsp_rdata[p*DW +: DW] === pend_d[p], req,
                      $sformatf("rsp_rdata port %0d", p), rsp_rdata[p*DW +: DW], pend_d[p]);
        end
    endtask

    task automatic step(input logic [115:0] v, input string req);
        logic [3:0] vld, wen, rdy;
        @(negedge clk);
        check_rsp(req);
        vld = v[115:112];
        wen = v[111:108];
        rdy = v[3:0];
        req_valid = vld;
        req_we    = wen;
        req_addr  = v[107:68];
        req_wdata = v[67:4];
        #1;
        check(req_ready === rdy, req, "req_ready", DW'(req_ready), DW'(rdy));
        for (int p = 0; p < 4; p++) begin
            int a;
            a = int'(v[68 + AW*p +: AW]);
            pend_v[p] = vld[p] && rdy[p] && !wen[p];
            pend_k[p] = written[a];
            pend_d[p] = model[a];
        end
        for (int p = 0; p < 4; p++) begin
            if (vld[p] && rdy[p] && wen[p]) begin
                model[int'(v[68 + AW*p +: AW])]   = v[4 + DW*p +: DW];
                written[int'(v[68 + AW*p +: AW])] = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            pend_v[i] = 1'b0;
            pend_k[i] = 1'b0;
            pend_d[i] = '0;
        end
        // R9: a read presented while in reset yields no response
        repeat (2) @(negedge clk);
        req_valid = 4'h1;
        req_addr  = '0;
        @(negedge clk);
        check(rsp_valid === 4'h0, "R9", "rsp_valid in reset", DW'(rsp_valid), 16'h0);
        req_valid = 4'h0;
        #1;
        check(req_ready === 4'h0, "R9/R8", "req_ready idle in reset", DW'(req_ready), 16'h0);
        @(negedge clk);
        check(rsp_valid === 4'h0, "R9", "rsp_valid after reset", DW'(rsp_valid), 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i], tag_of(i));
        end

        // R9: reset arriving with an accepted read suppresses its response
        @(negedge clk);
        check_rsp("R10");
        req_valid = 4'h1;
        req_we    = 4'h0;
        req_addr  = {30'd0, 10'd23};
        rst_n     = 1'b0;
        @(negedge clk);
        check(rsp_valid === 4'h0, "R9", "rsp_valid after reset with read",
              DW'(rsp_valid), 16'h0);
        req_valid = 4'h0;
        rst_n     = 1'b1;
        for (int i = 0; i < 4; i++) pend_v[i] = 1'b0;

        // R9: contents survive reset; R10 row 7 of bank 1 still distinct
        step({4'h3, 4'h0, 10'd0, 10'd0, 10'd29, 10'd23, 64'h0, 4'h3}, "R9/R10");
        step({4'h0, 4'h0, 40'd0, 64'h0, 4'h0}, "R9/R10");
        @(negedge clk);
        check_rsp("R5");

        report();
        $finish;
    end
endmodule